// File: doc/BRIEF.md
# Single-Port RAM with Runtime Sweep Clear

This block is a single-port synchronous RAM whose whole contents can be zeroed while the chip runs. The storage accepts only one write per clock, so it cannot be reset as a whole. A small controller instead walks every address in ascending order, writing one zero word per cycle. While the sweep runs, the block raises `busy` and turns away user accesses. When no sweep is running, the block behaves as a plain RAM. An access is taken only when `en` is high, a write happens when `we` is also high, and the registered output `dout` shows the addressed word one edge later. That word is the value held before any write in the same cycle.

A clear is requested by holding `clr_req_n` low for one or more cycles. A request made during a running sweep restarts the sweep from address 0. The chip reset `rst_n` is asserted asynchronously and released through a synchronizer. Its release also starts a sweep, so the array is known to be zero before first use. The address width `ADDR_W` is a parameter. A 14-bit address gives 16384 words and a 16384-cycle clear. The default is 10 bits, which keeps elaboration light. `DATA_W` defaults to 8.

Top module: `clearable_ram`

## Requirements
- R1: During reset `busy` is 1 and `dout` is 0. After `rst_n` is released at a falling clock edge, `busy` stays high for exactly 2^ADDR_W + 2 clock edges. The two extra edges are reset synchronization.
- R2: At the rising edge where `clr_req_n` is sampled low, `busy` becomes 1 and `dout` becomes 0.
- R3: After the last edge at which `clr_req_n` was sampled low, `busy` stays high for exactly 2^ADDR_W − 1 further edges. The sweep writes address 0 at the request edge and then one ascending address per edge, ending at 2^ADDR_W − 1.
- R4: After any sweep completes, every address reads back 0.
- R5: A request made while a sweep is running restarts the sweep from address 0. `busy` then lasts 2^ADDR_W − 1 edges past the new request, and all words read 0 afterwards.
- R6: While a sweep runs (request low or `busy` 1), `en`/`we` have no effect. Nothing is written, and `dout` stays 0.
- R7: With `en`=1 and `we`=1 while idle, `din` is stored at `addr`.
- R8: With `en`=1 while idle, `dout` takes the word at `addr` at that edge.
- R9: With `en`=0, no write occurs even if `we`=1, and `dout` holds its value.
- R10: On a write, `dout` returns the word's contents from before the write (read-first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; release starts a sweep |
| clr_req_n | input | 1 | Active-low clear request, sampled on each rising edge |
| en | input | 1 | User access enable |
| we | input | 1 | User write enable, qualified by `en` |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| busy | output | 1 | High while a sweep is in progress |

## Verification
The RAM path is tried with three patterns. An ascending fill of distinct values separates address decoding errors from data errors. A write to a word already holding a known value shows whether the read is read-first or write-first. A write attempted with `en` low shows whether enable gates both the store and the output register. The clear is tried from reset, from a single-cycle request and from a multi-cycle request issued partway through a sweep. Exact `busy` durations separate a correct restart from a sweep that simply continues. Reads and writes attempted during a sweep, followed by a full readback, show that user traffic is locked out and that no word is skipped.

// File: rtl/clr_ram_pkg.sv
package clr_ram_pkg;
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import clr_ram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_req_n,
  output logic              sweep_wr,
  output logic [ADDR_W-1:0] sweep_addr,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [ADDR_W-1:0] ONE_ADDR  = ADDR_W'(1);

  sweep_state_e      state_q, state_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              req_now;

  assign req_now    = !clr_req_n;
  assign sweep_wr   = req_now || (state_q == SW_RUN);
  assign sweep_addr = req_now ? '0 : cnt_q;
  assign busy       = (state_q == SW_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (req_now) begin
      state_d = SW_RUN;
      cnt_d   = ONE_ADDR;
    end else if (state_q == SW_RUN) begin
      if (cnt_q == LAST_ADDR) begin
        state_d = SW_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + ONE_ADDR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_RUN && clr_req_n && cnt_q != LAST_ADDR) |=> (cnt_q == $past(cnt_q) + ONE_ADDR));

  // R3
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_RUN && clr_req_n && cnt_q == LAST_ADDR) |=> (state_q == SW_IDLE));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req_n) |=> (busy && cnt_q == ONE_ADDR));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_IDLE && clr_req_n) |-> !sweep_wr);
endmodule

// File: rtl/access_mux.sv
module access_mux #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              sweep_wr,
  input  logic [ADDR_W-1:0] sweep_addr,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr
);
  logic user_go;

  assign user_go = en && !sweep_wr;

  always_comb begin
    if (sweep_wr) begin
      mem_we    = 1'b1;
      mem_waddr = sweep_addr;
      mem_wdata = '0;
    end else begin
      mem_we    = user_go && we;
      mem_waddr = addr;
      mem_wdata = din;
    end
    mem_re    = user_go;
    mem_raddr = addr;
  end
endmodule

// File: rtl/spram_core.sv
module spram_core #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              zero_out,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (zero_out) rdata_q <= '0;
    else if (rd_en)    rdata_q <= store[raddr];
  end

  assign rdata = rdata_q;

  // R2
  out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_out |=> (rdata == '0));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_out && !rd_en) |=> $stable(rdata));
endmodule

// File: rtl/clearable_ram.sv
module clearable_ram #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_req_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              busy
);
  logic              rst_n_int;
  logic              sweep_wr;
  logic [ADDR_W-1:0] sweep_addr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_re;
  logic [ADDR_W-1:0] mem_raddr;

  rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  sweep_ctrl #(.ADDR_W(ADDR_W)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr_req_n (clr_req_n),
    .sweep_wr  (sweep_wr),
    .sweep_addr(sweep_addr),
    .busy      (busy)
  );

  access_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .sweep_wr  (sweep_wr),
    .sweep_addr(sweep_addr),
    .en        (en),
    .we        (we),
    .addr      (addr),
    .din       (din),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr)
  );

  spram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .rd_en   (mem_re),
    .raddr   (mem_raddr),
    .zero_out(!clr_req_n),
    .rdata   (dout)
  );

  // R6
  locked_out_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (busy || !clr_req_n) |=> (dout == '0));
endmodule

// File: tb/sim_clearable_ram.sv
`timescale 1ns/1ps
module sim_clearable_ram;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    logic [DW-1:0] val;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n, clr_req_n, en, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          busy;

  exp_t          q[$];
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_dout;
  bit            sweeping;
  bit            done;
  int            checks, fails;

  always #2 clk = ~clk;

  clearable_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_req_n(clr_req_n), .en(en), .we(we),
    .addr(addr), .din(din), .dout(dout), .busy(busy)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.tag, 32'(dout), 32'(e.val));
    end
  end

  task automatic acc(bit e, bit w, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    @(negedge clk);
    en = e; we = w; addr = a; din = d;
    @(posedge clk);
    #1;
    if (e && !sweeping) begin
      exp_dout = model[a];
      if (w) model[a] = d;
    end
    q.push_back('{exp_dout, tag});
  endtask

  task automatic idle();
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic count_busy(int expn, string tag);
    int n = 0;
    while (busy === 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk(tag, 32'(n), 32'(expn));
    sweeping = 1'b0;
  endtask

  task automatic start_clear(int low_cycles, string tag);
    @(negedge clk);
    en = 1'b0; we = 1'b0; clr_req_n = 1'b0;
    repeat (low_cycles - 1) @(negedge clk);
    @(negedge clk);
    clr_req_n = 1'b1;
    sweeping = 1'b1;
    exp_dout = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    chk({tag, " busy at request"}, 32'(busy), 32'd1);
    chk({tag, " dout zero at request"}, 32'(dout), 32'd0);
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < DEPTH; i++) acc(1'b1, 1'b0, AW'(i), '0, tag);
    idle();
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_req_n = 1'b1; en = 1'b0; we = 1'b0; addr = '0; din = '0;
    exp_dout = '0; sweeping = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy in reset", 32'(busy), 32'd1);
    chk("R1 dout in reset", 32'(dout), 32'd0);
    rst_n = 1'b1;
    count_busy(DEPTH + 2, "R1 busy length after reset");
    read_all("R4 zero after reset sweep");

    // R7 R8 ascending fill, then descending readback
    for (int i = 0; i < DEPTH; i++) acc(1'b1, 1'b1, AW'(i), DW'(i * 7 + 3), "R7 fill");
    for (int i = DEPTH - 1; i >= 0; i -= 37) acc(1'b1, 1'b0, AW'(i), '0, "R8 readback");
    acc(1'b1, 1'b0, AW'(DEPTH - 1), '0, "R8 top address");

    // R9 write with enable low
    acc(1'b0, 1'b1, AW'(9), 8'hEE, "R9 hold with en low");
    acc(1'b0, 1'b0, AW'(4), 8'h00, "R9 hold idle");
    acc(1'b1, 1'b0, AW'(9), '0, "R9 word untouched");

    // R10 read-first
    acc(1'b1, 1'b1, AW'(5), 8'h11, "R10 setup");
    acc(1'b1, 1'b1, AW'(5), 8'h22, "R10 old value returned");
    acc(1'b1, 1'b0, AW'(5), '0, "R10 new value stored");

    // R2 R6 R3 single-cycle request with traffic during sweep
    acc(1'b1, 1'b0, AW'(20), '0, "R8 nonzero before clear");
    idle();
    drain();
    chk("R2 dout nonzero before clear", 32'(dout != '0), 32'd1);
    start_clear(1, "R2");
    acc(1'b1, 1'b1, AW'(3), 8'h5A, "R6 write ignored while busy");
    acc(1'b1, 1'b0, AW'(20), '0, "R6 read blocked while busy");
    idle();
    count_busy(DEPTH - 1 - 3, "R3 busy length after request");
    drain();
    acc(1'b1, 1'b0, AW'(3), '0, "R6 blocked write did not land");
    read_all("R4 zero after request sweep");

    // R5 restart during a sweep
    for (int i = 0; i < DEPTH; i++) acc(1'b1, 1'b1, AW'(i), DW'(i ^ 8'hA5) | DW'(1), "R7 refill");
    idle();
    drain();
    start_clear(1, "R5 first");
    repeat (400) @(negedge clk);
    chk("R5 still busy mid sweep", 32'(busy), 32'd1);
    start_clear(3, "R5 second");
    count_busy(DEPTH - 1, "R5 busy length after restart");
    read_all("R5 zero after restarted sweep");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule